// File: doc/BRIEF.md
# Two-Phase Peak-Current PWM Sequencer

This block is the digital steering logic of a two-phase, fixed-frequency, current-mode step-down regulator controller. A single oscillator tick, one clock wide, sets one phase output high. Successive ticks alternate between the two phase outputs, so each phase switches at half the tick rate. A peak-current comparator flag is shared by both phases. When that flag arrives, after it has been resynchronised into the clock domain, it ends the active on-time early.

A programmable blanking window after every set ignores the comparator. This rejects leading-edge switching noise. If the comparator never trips, the next tick ends the on-time just as the other phase starts. Because of this, each phase is limited to half the period and the two outputs never overlap.

A 5-bit voltage identification code of all ones means that no processor is fitted. That code, or a low enable input, holds both outputs low. When operation resumes, the sequence restarts at phase A. A small status pair reports the phase that fired last and how its last on-time ended.

Top module: `twophase_pwm_seq`

## Requirements
- R1: While running (enable high and ID code not all ones), a tick sampled at a clock edge drives the selected phase output high from that edge on.
- R2: The selected phase alternates on every running tick, phase A first after reset. A tick that finds phase A high leaves phase B high after the edge.
- R3: The current flag passes through a 2-flop synchronizer. When the synchronised flag is high at an edge outside blanking, and no tick is present, the active output goes low until the next tick.
- R4: The phase A and phase B outputs are never high in the same cycle.
- R5: For BLANK_CYC clock edges after a set edge, the synchronised flag is ignored and the active output stays high.
- R6: If no trip occurs, the active output goes low at the next tick edge, the same edge that sets the other phase.
- R7: An ID code of all ones (5'h1F) holds both outputs low and suspends toggling. The first tick after a valid code returns sets phase A.
- R8: A low enable holds both outputs low. The first tick after enable returns sets phase A.
- R9: A synchronous active-low reset clears both outputs, the phase selector, the blanking counter, the synchronizer and the status outputs.
- R10: stat_phase_o gives the phase set by the latest running tick (0 = A, 1 = B). stat_trip_o becomes 1 when an on-time ends by comparator trip and 0 when it ends at a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Enable (lockout release), active high |
| tick_i | input | 1 | Oscillator tick, one clock wide |
| ilim_i | input | 1 | Peak-current comparator flag, asynchronous |
| vid_i | input | ID_W | Voltage identification code |
| ph_a_o | output | 1 | Phase A drive request |
| ph_b_o | output | 1 | Phase B drive request |
| stat_phase_o | output | 1 | Phase set by the latest tick |
| stat_trip_o | output | 1 | Last on-time ended by comparator trip |

## Verification
Tick periods are run with no comparator activity, which separates the tick-limited turn-off from the trip path. A single-clock comparator pulse placed inside the blanking window is contrasted with one placed after it, showing that blanking suppresses the first and not the second. A held flag that starts during blanking shows the trip deferred to the first unblanked edge. Sequences that drop enable, present the all-ones code, or reset mid-period check that the sequence restarts at phase A. A final mixed run of varied period lengths and trip offsets exercises how the status outputs follow both kinds of ending.

// File: rtl/tpw_pkg.sv
package tpw_pkg;
   typedef enum logic {
      PH_A = 1'b0,
      PH_B = 1'b1
   } phase_e;
endpackage

// File: rtl/tpw_sync.sv
module tpw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tpw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] shreg;

   always_ff @(posedge clk) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[STAGES-2:0], d_i};
   end

   assign q_o = shreg[STAGES-1];
endmodule

// File: rtl/tpw_blank.sv
module tpw_blank #(
   parameter int BLANK_W   = 4,
   parameter int BLANK_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic load_i,
   output logic busy_o
);
   localparam logic [BLANK_W-1:0] LOAD_VAL = BLANK_W'(BLANK_CYC);

   logic [BLANK_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) cnt <= '0;
      else if (load_i)     cnt <= LOAD_VAL;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy_o = (cnt != '0);

   // R5: a freshly loaded window stays busy for the next edge when non-empty
   assert_blank_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !clr_i && BLANK_CYC > 0) |=> busy_o);
endmodule

// File: rtl/tpw_core.sv
module tpw_core
   import tpw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic tick_i,
   input  logic trip_i,
   input  logic blank_i,
   output logic set_o,
   output logic ph_a_o,
   output logic ph_b_o,
   output logic stat_phase_o,
   output logic stat_trip_o
);
   phase_e sel;
   logic   active;

   assign active = ph_a_o | ph_b_o;
   assign set_o  = run_i & tick_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel          <= PH_A;
         ph_a_o       <= 1'b0;
         ph_b_o       <= 1'b0;
         stat_phase_o <= 1'b0;
         stat_trip_o  <= 1'b0;
      end else if (!run_i) begin
         sel    <= PH_A;
         ph_a_o <= 1'b0;
         ph_b_o <= 1'b0;
      end else if (tick_i) begin
         if (active) stat_trip_o <= 1'b0;
         ph_a_o       <= (sel == PH_A);
         ph_b_o       <= (sel == PH_B);
         stat_phase_o <= sel;
         sel          <= (sel == PH_A) ? PH_B : PH_A;
      end else if (trip_i && !blank_i && active) begin
         ph_a_o      <= 1'b0;
         ph_b_o      <= 1'b0;
         stat_trip_o <= 1'b1;
      end
   end

   assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(ph_a_o && ph_b_o));

   assert_tick_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && tick_i) |=> (ph_a_o || ph_b_o));

   assert_alternate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && tick_i && ph_a_o) |=> ph_b_o);

   assert_tick_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && tick_i && ph_b_o) |=> (ph_a_o && !stat_trip_o));

   assert_trip_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !tick_i && trip_i && !blank_i) |=> !(ph_a_o || ph_b_o));

   assert_blank_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !tick_i && blank_i && ph_a_o) |=> ph_a_o);

   // covers R7 and R8: idle gating from either cause
   assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !(ph_a_o || ph_b_o));
endmodule

// File: rtl/twophase_pwm_seq.sv
module twophase_pwm_seq #(
   parameter int ID_W        = 5,
   parameter int SYNC_STAGES = 2,
   parameter int BLANK_W     = 4,
   parameter int BLANK_CYC   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_i,
   input  logic            tick_i,
   input  logic            ilim_i,
   input  logic [ID_W-1:0] vid_i,
   output logic            ph_a_o,
   output logic            ph_b_o,
   output logic            stat_phase_o,
   output logic            stat_trip_o
);
   localparam int BLANK_MAX = (1 << BLANK_W) - 1;

   generate
      if (ID_W < 1) begin : g_bad_id
         $error("twophase_pwm_seq: ID_W must be at least 1");
      end
      if (BLANK_CYC < 0 || BLANK_CYC > BLANK_MAX) begin : g_bad_blank
         $error("twophase_pwm_seq: BLANK_CYC does not fit BLANK_W");
      end
   endgenerate

   logic no_cpu, run, trip_s, blank_busy, set_pulse;

   assign no_cpu = &vid_i;
   assign run    = en_i & ~no_cpu;

   tpw_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ilim_i),
      .q_o   (trip_s)
   );

   tpw_blank #(.BLANK_W(BLANK_W), .BLANK_CYC(BLANK_CYC)) blank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (~run),
      .load_i (set_pulse),
      .busy_o (blank_busy)
   );

   tpw_core core_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_i        (run),
      .tick_i       (tick_i),
      .trip_i       (trip_s),
      .blank_i      (blank_busy),
      .set_o        (set_pulse),
      .ph_a_o       (ph_a_o),
      .ph_b_o       (ph_b_o),
      .stat_phase_o (stat_phase_o),
      .stat_trip_o  (stat_trip_o)
   );

   assert_nocpu_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (no_cpu && $past(no_cpu)) |-> !(ph_a_o || ph_b_o));

   assert_reset_clear_R9: assert property (@(posedge clk)
      !rst_n |=> !(ph_a_o || ph_b_o || stat_trip_o || stat_phase_o));
endmodule

// File: tb/twophase_pwm_seq_tb_top.sv
module twophase_pwm_seq_tb_top;
   localparam int BLANK = 3;

   logic clk = 1'b0;
   logic rst_n, en, tick, ilim;
   logic [4:0] vid;
   logic ph_a, ph_b, st_ph, st_tr;

   int n_checks = 0;
   int n_err    = 0;
   int cyc      = 0;
   bit done     = 1'b0;

   // behavioural reference state
   int m_a = 0, m_b = 0, m_next = 0, m_sph = 0, m_str = 0, m_blank = 0;
   int syncq[$] = '{0, 0};

   always #4 clk = ~clk;

   twophase_pwm_seq #(.ID_W(5), .SYNC_STAGES(2), .BLANK_W(4), .BLANK_CYC(BLANK)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (en),
      .tick_i       (tick),
      .ilim_i       (ilim),
      .vid_i        (vid),
      .ph_a_o       (ph_a),
      .ph_b_o       (ph_b),
      .stat_phase_o (st_ph),
      .stat_trip_o  (st_tr)
   );

   always @(posedge clk) begin
      int flag;
      bit go;
      flag = syncq[0];
      go   = en && (vid != 5'h1F);
      if (!rst_n) begin
         m_a = 0; m_b = 0; m_next = 0; m_sph = 0; m_str = 0; m_blank = 0;
         syncq = '{0, 0};
      end else begin
         void'(syncq.pop_front());
         syncq.push_back(int'(ilim));
         if (!go) begin
            m_a = 0; m_b = 0; m_next = 0; m_blank = 0;
         end else if (tick) begin
            if (m_a + m_b > 0) m_str = 0;
            m_a = (m_next == 0); m_b = (m_next == 1);
            m_sph = m_next; m_next = 1 - m_next; m_blank = BLANK;
         end else if (m_blank > 0) begin
            m_blank--;
         end else if (flag != 0 && (m_a + m_b) > 0) begin
            m_a = 0; m_b = 0; m_str = 1;
         end
      end
   end

   task automatic lit(bit ok, string tag, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk(string tag);
      lit(ph_a == m_a[0], tag, ph_a, m_a);
      lit(ph_b == m_b[0], tag, ph_b, m_b);
      lit(st_ph == m_sph[0], "R10", st_ph, m_sph);
      lit(st_tr == m_str[0], "R10", st_tr, m_str);
   endtask

   always @(negedge clk) begin
      if (!done) begin
         cyc++;
         chk("R1");
         lit(!(ph_a && ph_b), "R4", ph_a + ph_b, 1);
         if (cyc > 100000) begin
            done = 1'b1;
            lit(1'b0, "watchdog", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
         end
      end
   end

   task automatic period(int len, int trip_from);
      for (int i = 0; i < len; i++) begin
         tick = (i == 0);
         ilim = (trip_from >= 0 && i >= trip_from);
         @(negedge clk);
      end
      tick = 1'b0; ilim = 1'b0;
   endtask

   task automatic period_pulse(int len, int at);
      for (int i = 0; i < len; i++) begin
         tick = (i == 0);
         ilim = (i == at);
         @(negedge clk);
      end
      tick = 1'b0; ilim = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; en = 1'b0; tick = 1'b0; ilim = 1'b0; vid = 5'h00;
      repeat (3) @(negedge clk);
      chk("R9");
      lit(ph_a == 1'b0 && ph_b == 1'b0, "R9", ph_a + ph_b, 0);
      rst_n = 1'b1; en = 1'b1; vid = 5'h0A;
      @(negedge clk);
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      lit(ph_a == 1'b1, "R2", ph_a, 1);
      repeat (9) @(negedge clk);
      period(10, -1);
      lit(ph_b == 1'b1 && ph_a == 1'b0, "R6", ph_b, 1);
      chk("R2");
      period(10, 1);
      chk("R3");
      lit(ph_a == 1'b0 && st_tr == 1'b1, "R3", ph_a, 0);
      period_pulse(10, 0);
      chk("R5");
      lit(ph_b == 1'b1, "R5", ph_b, 1);
      period_pulse(10, 5);
      chk("R3");
      vid = 5'h1F;
      period(10, -1); period(10, 3);
      chk("R7");
      lit(ph_a == 1'b0 && ph_b == 1'b0, "R7", ph_a + ph_b, 0);
      vid = 5'h03;
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      lit(ph_a == 1'b1, "R7", ph_a, 1);
      repeat (5) @(negedge clk);
      period(10, -1);
      en = 1'b0;
      period(10, -1);
      chk("R8");
      en = 1'b1;
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      lit(ph_a == 1'b1, "R8", ph_a, 1);
      repeat (4) @(negedge clk);
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      chk("R9");
      lit(st_ph == 1'b0 && st_tr == 1'b0 && ph_a == 1'b0, "R9", st_ph + st_tr, 0);
      period(8, -1);
      lit(ph_a == 1'b1, "R9", ph_a, 1);
      for (int k = 0; k < 30; k++) begin
         period(5 + k % 6, (k % 3 == 0) ? -1 : k % 8);
      end
      chk("R10");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end
endmodule